// File: doc/BRIEF.md
# Two-Dimensional Memory Fill Sequencer

This block writes a rectangular pattern into a memory region through a write port that accepts one word per clock. It walks an outer index over `N_OUTER` values and an inner index over `N_INNER` values. Each visited pair produces one write. The data word is computed from the pair, and the address is a running linear address that starts at a base and climbs by one per write.

A one-cycle `start` pulse captures the base address and begins a fill. The block then issues `N_OUTER * N_INNER` back-to-back writes and raises `done`. A new `start` repeats the fill, and it may be given at any time, including in the middle of a fill. The pattern formula is a placeholder that can be set through parameters. A user replaces it with the real formula in the package function.

Top module: `fill_seq2d`

## Requirements
- R1: While reset is held and on the first cycle after it, `mem_we`, `busy` and `done` are 0.
- R2: In the cycle after a `start` pulse, the block begins writing. It then asserts `mem_we` on exactly `N_OUTER*N_INNER` consecutive cycles, one write per cycle, and `busy` is high on exactly those cycles.
- R3: The first write goes to the `base_addr` value sampled with `start`. Each later write goes to the previous address plus one, modulo 2^`ADDR_W`.
- R4: The inner index starts at 0 and advances by one per write. After `N_INNER-1` it returns to 0.
- R5: The outer index starts at 0 and advances only on writes where the inner index returns to 0.
- R6: On the write for pair (i, j), `mem_wdata` equals the low `DATA_W` bits of `((i << 8) XOR (j * 3)) + PAT_SEED`, computed at 32 bits.
- R7: After the write with i = `N_OUTER-1` and j = `N_INNER-1`, `done` goes to 1 on the next cycle. `done` then stays 1 with `mem_we` at 0 until the next `start`.
- R8: A `start` pulse clears `done` and restarts the fill from pair (0, 0) at the new base, even during a fill. The write already present in the `start` cycle is still issued. A `start` in the cycle of the final write wins over setting `done`.
- R9: A completed fill leaves memory words base .. base+`N_OUTER*N_INNER`-1 holding the pattern of R6 in linear order.
- R10: Changes on `base_addr` outside a `start` cycle have no effect on the addresses written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that (re)starts a fill |
| base_addr | input | ADDR_W | First write address, sampled with `start` |
| mem_we | output | 1 | Write enable to the memory |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | DATA_W | Write data |
| busy | output | 1 | A fill is in progress |
| done | output | 1 | Last fill finished; held until next `start` |

## Verification
Two events can fall in the same cycle. One is a `start` pulse. The other is either the final write with its double wrap, or an ordinary mid-fill write. The bench provokes both cases by raising `start` on the exact cycle where the reference model predicts the last beat or beat seven. It checks that the write of that cycle still appears at its old address, and that the next cycle shows `done` low and pair (0, 0) at the new base. Random bases, including one near the top of the address space, and a `base_addr` that changes every cycle during fills, are checked beat by beat against a bench model. The test RAM contents are also checked after each fill.

// File: rtl/fill_pkg.sv
package fill_pkg;

    typedef enum logic [0:0] {
        FS_IDLE = 1'b0,
        FS_RUN  = 1'b1
    } fill_state_e;

    // Placeholder pattern: outer index in upper byte lanes, inner index scaled.
    function automatic logic [31:0] pat_word(input logic [31:0] oi,
                                             input logic [31:0] ii,
                                             input logic [31:0] seed);
        return ((oi << 8) ^ (ii * 32'd3)) + seed;
    endfunction

    function automatic int unsigned idx_width(input int unsigned limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/fill_wrap_ctr.sv
module fill_wrap_ctr #(
    parameter int unsigned LIMIT = 4,
    parameter int unsigned W     = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] value,
    output logic         at_last
);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    generate
        if (LIMIT <= 1) begin : g_single
            assign value   = '0;
            assign at_last = 1'b1;
        end else begin : g_count
            logic [W-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    cnt_q <= '0;
                end else if (step) begin
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + W'(1);
                end
            end
            assign value   = cnt_q;
            assign at_last = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/fill_addr_gen.sv
module fill_addr_gen #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= base;
        end else if (step) begin
            addr_q <= addr_q + ADDR_W'(1);
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/fill_pattern.sv
module fill_pattern #(
    parameter int unsigned OI_W     = 2,
    parameter int unsigned II_W     = 3,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned PAT_SEED = 32'h1234
) (
    input  logic [OI_W-1:0]   outer_idx,
    input  logic [II_W-1:0]   inner_idx,
    output logic [DATA_W-1:0] word
);
    logic [31:0] full;

    always_comb begin
        full = fill_pkg::pat_word(32'(outer_idx), 32'(inner_idx), 32'(PAT_SEED));
        word = full[DATA_W-1:0];
    end
endmodule

// File: rtl/fill_seq2d.sv
module fill_seq2d #(
    parameter int unsigned N_OUTER  = 4,
    parameter int unsigned N_INNER  = 5,
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned PAT_SEED = 32'h1234
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done
);
    import fill_pkg::*;

    localparam int unsigned OI_W = idx_width(N_OUTER);
    localparam int unsigned II_W = idx_width(N_INNER);

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_beat_t;

    fill_state_e     state_q;
    logic            done_q;
    logic            run;
    logic [OI_W-1:0] outer_idx;
    logic [II_W-1:0] inner_idx;
    logic            outer_last;
    logic            inner_last;
    logic            final_beat;
    logic [ADDR_W-1:0] addr_cur;
    logic [DATA_W-1:0] pat_cur;
    wr_beat_t        beat;

    assign run        = (state_q == FS_RUN);
    assign final_beat = run && inner_last && outer_last;

    fill_wrap_ctr #(.LIMIT(N_INNER), .W(II_W)) u_inner (
        .clk(clk), .rst(rst), .clr(start), .step(run),
        .value(inner_idx), .at_last(inner_last)
    );

    fill_wrap_ctr #(.LIMIT(N_OUTER), .W(OI_W)) u_outer (
        .clk(clk), .rst(rst), .clr(start), .step(run && inner_last),
        .value(outer_idx), .at_last(outer_last)
    );

    fill_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst(rst), .load(start), .base(base_addr),
        .step(run), .addr(addr_cur)
    );

    fill_pattern #(.OI_W(OI_W), .II_W(II_W), .DATA_W(DATA_W),
                   .PAT_SEED(PAT_SEED)) u_pat (
        .outer_idx(outer_idx), .inner_idx(inner_idx), .word(pat_cur)
    );

    // start has priority over finishing
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            done_q  <= 1'b0;
        end else if (start) begin
            state_q <= FS_RUN;
            done_q  <= 1'b0;
        end else if (final_beat) begin
            state_q <= FS_IDLE;
            done_q  <= 1'b1;
        end
    end

    always_comb begin
        beat.we   = run;
        beat.addr = addr_cur;
        beat.data = pat_cur;
    end

    assign mem_we    = beat.we;
    assign mem_addr  = beat.addr;
    assign mem_wdata = beat.data;
    assign busy      = run;
    assign done      = done_q;
endmodule

// File: rtl/fill_seq2d_chk.sv
module fill_seq2d_chk #(
    parameter int unsigned N_OUTER = 4,
    parameter int unsigned N_INNER = 5,
    parameter int unsigned ADDR_W  = 10,
    parameter int unsigned DATA_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [ADDR_W-1:0] base_addr,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              done
);
    localparam int unsigned TOTAL = N_OUTER * N_INNER;

    int unsigned wr_cnt;
    always_ff @(posedge clk) begin
        if (rst || start) wr_cnt <= 0;
        else if (mem_we)  wr_cnt <= wr_cnt + 1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!mem_we && !done && !busy));

    assert_busy_writes_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> mem_we);

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !start) |=> (!mem_we || mem_addr == $past(mem_addr) + ADDR_W'(1)));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_we);

    assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    assert_start_base_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> (mem_we && !done && mem_addr == $past(base_addr)));

    assert_write_total_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (wr_cnt == TOTAL));
endmodule

bind fill_seq2d fill_seq2d_chk #(
    .N_OUTER(N_OUTER), .N_INNER(N_INNER), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .mem_we(mem_we), .mem_addr(mem_addr), .busy(busy), .done(done)
);

// File: tb/fill_seq2d_tb_top.sv
`timescale 1ns/1ps
module fill_seq2d_tb_top;
    localparam int unsigned NI    = 4;
    localparam int unsigned NJ    = 5;
    localparam int unsigned AW    = 10;
    localparam int unsigned DW    = 16;
    localparam int unsigned SEED  = 32'h1234;
    localparam int unsigned TOTAL = NI * NJ;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          busy;
    logic          done;

    int unsigned checks = 0;
    int unsigned errs   = 0;

    always #10 clk = ~clk;

    fill_seq2d #(.N_OUTER(NI), .N_INNER(NJ), .ADDR_W(AW), .DATA_W(DW),
                 .PAT_SEED(SEED)) dut_i (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .done(done)
    );

    logic [DW-1:0] ram [0:(1<<AW)-1];
    always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

    function automatic logic [DW-1:0] exp_data(input int k);
        logic [31:0] w;
        w = ((32'(k / NJ) << 8) ^ (32'(k % NJ) * 32'd3)) + SEED;
        return w[DW-1:0];
    endfunction

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input int k);
        return b + AW'(k);
    endfunction

    task automatic chk(input logic ok, input string req,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue_start(input logic [AW-1:0] b);
        start = 1'b1;
        base_addr = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    // check write beat k of a fill based at b (sampled at negedge)
    task automatic check_beat(input logic [AW-1:0] b, input int k, input bit jiggle);
        chk(mem_we && busy, "R2 write enable", {mem_we, busy}, 2'b11);
        chk(!done, "R8 done low during fill", done, 0);
        chk(mem_addr == exp_addr(b, k), "R3 R10 address", mem_addr, exp_addr(b, k));
        chk(mem_wdata == exp_data(k), "R4 R5 R6 data", mem_wdata, exp_data(k));
        if (jiggle) base_addr = AW'($urandom);
    endtask

    task automatic check_stream(input logic [AW-1:0] b, input int from, input int upto,
                                input bit jiggle);
        for (int k = from; k < upto; k++) begin
            check_beat(b, k, jiggle);
            @(negedge clk);
        end
    endtask

    task automatic check_finished(input logic [AW-1:0] b);
        chk(!mem_we && !busy && done, "R7 done after last write",
            {mem_we, busy, done}, 3'b001);
        for (int h = 0; h < 3; h++) begin
            base_addr = AW'($urandom);
            @(negedge clk);
            chk(!mem_we && done, "R7 done held, no writes", {mem_we, done}, 2'b01);
        end
        for (int k = 0; k < TOTAL; k++)
            chk(ram[exp_addr(b, k)] == exp_data(k), "R9 memory contents",
                ram[exp_addr(b, k)], exp_data(k));
    endtask

    task automatic full_fill(input logic [AW-1:0] b, input bit jiggle);
        issue_start(b);
        check_stream(b, 0, TOTAL, jiggle);
        check_finished(b);
    endtask

    initial begin
        logic [AW-1:0] b1, b2;
        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        chk(!mem_we && !busy && !done, "R1 in reset", {mem_we, busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_we && !busy && !done, "R1 after reset", {mem_we, busy, done}, 0);

        // directed: base zero, then top-of-space wrap
        full_fill('0, 1'b0);
        full_fill(AW'((1 << AW) - 7), 1'b0);

        // random bases, base_addr toggling during fill (R10)
        for (int n = 0; n < 5; n++) full_fill(AW'($urandom), 1'b1);

        // R8: restart in mid-fill at beat 7
        b1 = AW'($urandom);
        b2 = AW'($urandom);
        issue_start(b1);
        check_stream(b1, 0, 7, 1'b0);
        check_beat(b1, 7, 1'b0);
        issue_start(b2);
        check_stream(b2, 0, TOTAL, 1'b0);
        check_finished(b2);

        // R8: start together with the final write
        b1 = AW'($urandom);
        b2 = AW'($urandom);
        issue_start(b1);
        check_stream(b1, 0, TOTAL - 1, 1'b0);
        check_beat(b1, TOTAL - 1, 1'b0);
        issue_start(b2);
        chk(!done, "R8 start beats final wrap", done, 0);
        check_stream(b2, 0, TOTAL, 1'b1);
        check_finished(b2);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule